// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one accepted column access command into the sequence of column addresses a memory array visits across the beats of a burst. Each command carries a starting column and an on-the-fly length bit. A two-bit burst-length mode and a burst-type bit are applied alongside it. The block latches these inputs when it accepts the command. It then issues one column address per clock until the burst completes.

The beats stay inside an aligned group of columns whose size equals the burst length, which is either 4 beats (chop) or 8 beats. The low column bits walk through the group and wrap at its edge. They never carry into the bits that select the group. Two orderings are available: sequential, where the offset counts up modulo the length, and interleaved, where the offset is the starting offset XORed with the beat number. A command is accepted only while no burst is running. A reserved mode value is rejected and reported.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `beat_valid`, `beat_last`, `mode_err` are 0, `burst_len` is 0 and `cmd_ready` is 1.
- R2: The mode input encodes 2'b00 as a fixed 8-beat burst and 2'b10 as a fixed 4-beat (chop) burst; during a burst `burst_len` shows 8 or 4 accordingly and ignores `cmd_a12`.
- R3: With mode 2'b01 the length follows `cmd_a12` of the command: 0 gives 4 beats, 1 gives 8 beats.
- R4: A command offered with mode 2'b11 starts no burst; `mode_err` is 1 for exactly the cycle after it and `cmd_ready` stays 1.
- R5: In a 4-beat burst every beat keeps column bits [COL_W-1:2] of the starting column; in an 8-beat burst every beat keeps bits [COL_W-1:3].
- R6: With `burst_type` 0 (sequential), beat k carries low offset (start offset + k) modulo the burst length, where the offset is bits [1:0] for 4 beats and [2:0] for 8 beats.
- R7: With `burst_type` 1 (interleaved), beat k carries low offset (start offset XOR k).
- R8: The first beat appears in the cycle after acceptance, the beats occupy consecutive cycles, and `beat_last` is 1 only on beat 3 of a 4-beat burst and beat 7 of an 8-beat burst.
- R9: `cmd_ready` is 0 from the cycle after acceptance through the last beat; a command offered then is ignored; `cmd_ready` returns to 1 in the cycle after the last beat.
- R10: Mode, `cmd_a12`, `burst_type` and `cmd_col` are sampled only at acceptance; changing them mid-burst has no effect on the beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Column command offered |
| cmd_ready | output | 1 | High when a command can be accepted |
| cmd_col | input | COL_W | Starting column address |
| cmd_a12 | input | 1 | Per-command length select for on-the-fly mode (1 = 8 beats) |
| bl_mode | input | 2 | Burst-length mode: 00 fixed 8, 01 on-the-fly, 10 fixed 4, 11 reserved |
| burst_type | input | 1 | 0 sequential ordering, 1 interleaved ordering |
| beat_valid | output | 1 | A beat address is present |
| beat_col | output | COL_W | Column address of the current beat |
| beat_last | output | 1 | Current beat is the final one |
| burst_len | output | 4 | Effective length of the running burst (4 or 8), 0 when idle |
| mode_err | output | 1 | One-cycle pulse after a command with reserved mode |

## Verification
If the beat index drifts, the wrong low offset shows on `beat_col` in the very next beat. A misplaced end shows as `beat_last` on the wrong beat or as `cmd_ready` recovering early or late, within one cycle of the expected last beat. A wrong latched length or ordering shows as the block-select bits changing or the offset pattern breaking by beat 1. The sweep covers every start offset under each mode, length bit and ordering, so any such fault appears within the first affected burst.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

   typedef enum logic [1:0] {
      BLM_FIX8  = 2'b00,
      BLM_OTF   = 2'b01,
      BLM_CHOP4 = 2'b10,
      BLM_RSVD  = 2'b11
   } bl_mode_e;

   localparam int unsigned OFFS_W = 3;

   typedef struct packed {
      logic len8;
      logic legal;
   } len_sel_t;

   function automatic len_sel_t decode_len(input logic [1:0] mode, input logic a12);
      len_sel_t r;
      r.legal = 1'b1;
      case (bl_mode_e'(mode))
         BLM_FIX8:  r.len8 = 1'b1;
         BLM_OTF:   r.len8 = a12;
         BLM_CHOP4: r.len8 = 1'b0;
         default: begin
            r.len8  = 1'b0;
            r.legal = 1'b0;
         end
      endcase
      return r;
   endfunction

endpackage

// File: rtl/burst_col_decode.sv
module burst_col_decode
   import burst_col_pkg::*;
(
   input  logic [1:0] mode,
   input  logic       a12,
   output logic       len8,
   output logic       legal
);
   len_sel_t sel;

   always_comb begin
      sel   = decode_len(mode, a12);
      len8  = sel.len8;
      legal = sel.legal;
   end
endmodule

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
   import burst_col_pkg::*;
#(
   parameter int unsigned COL_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               accept,
   input  logic               reject,
   input  logic               len8_in,
   input  logic               itype_in,
   input  logic [COL_W-1:0]   col_in,
   output logic               busy,
   output logic               last,
   output logic [OFFS_W-1:0]  idx,
   output logic               len8,
   output logic               itype,
   output logic [COL_W-1:0]   base,
   output logic               err
);
   localparam logic [OFFS_W-1:0] LAST8 = OFFS_W'(7);
   localparam logic [OFFS_W-1:0] LAST4 = OFFS_W'(3);

   assign last = busy && (idx == (len8 ? LAST8 : LAST4));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         idx   <= '0;
         len8  <= 1'b0;
         itype <= 1'b0;
         base  <= '0;
         err   <= 1'b0;
      end else begin
         err <= reject;
         if (accept) begin
            busy  <= 1'b1;
            idx   <= '0;
            len8  <= len8_in;
            itype <= itype_in;
            base  <= col_in;
         end else if (busy) begin
            if (last) begin
               busy <= 1'b0;
               idx  <= '0;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/burst_col_addr.sv
module burst_col_addr
   import burst_col_pkg::*;
#(
   parameter int unsigned COL_W = 10
) (
   input  logic [COL_W-1:0]  base,
   input  logic [OFFS_W-1:0] idx,
   input  logic              len8,
   input  logic              itype,
   output logic [COL_W-1:0]  col
);
   logic [OFFS_W-1:0] seq_offs;
   logic [OFFS_W-1:0] ilv_offs;
   logic [OFFS_W-1:0] offs;

   assign seq_offs = base[OFFS_W-1:0] + idx;

   for (genvar b = 0; b < OFFS_W; b++) begin : g_ilv
      assign ilv_offs[b] = base[b] ^ idx[b];
   end

   assign offs = itype ? ilv_offs : seq_offs;

   always_comb begin
      col      = base;
      col[1:0] = offs[1:0];
      if (len8) col[2] = offs[2];
   end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
   import burst_col_pkg::*;
#(
   parameter int unsigned COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [COL_W-1:0] cmd_col,
   input  logic             cmd_a12,
   input  logic [1:0]       bl_mode,
   input  logic             burst_type,
   output logic             beat_valid,
   output logic [COL_W-1:0] beat_col,
   output logic             beat_last,
   output logic [3:0]       burst_len,
   output logic             mode_err
);
   if (COL_W < OFFS_W + 1) begin : g_bad_width
      $error("burst_col_seq: COL_W must exceed the 8-beat offset width");
   end

   logic              dec_len8;
   logic              dec_legal;
   logic              accept;
   logic              reject;
   logic              busy;
   logic              last;
   logic [OFFS_W-1:0] idx;
   logic              len8;
   logic              itype;
   logic [COL_W-1:0]  base;

   burst_col_decode u_dec (
      .mode  (bl_mode),
      .a12   (cmd_a12),
      .len8  (dec_len8),
      .legal (dec_legal)
   );

   assign cmd_ready = !busy;
   assign accept    = cmd_valid && cmd_ready && dec_legal;
   assign reject    = cmd_valid && cmd_ready && !dec_legal;

   burst_col_ctrl #(.COL_W(COL_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .reject   (reject),
      .len8_in  (dec_len8),
      .itype_in (burst_type),
      .col_in   (cmd_col),
      .busy     (busy),
      .last     (last),
      .idx      (idx),
      .len8     (len8),
      .itype    (itype),
      .base     (base),
      .err      (mode_err)
   );

   burst_col_addr #(.COL_W(COL_W)) u_addr (
      .base  (base),
      .idx   (idx),
      .len8  (len8),
      .itype (itype),
      .col   (beat_col)
   );

   assign beat_valid = busy;
   assign beat_last  = last;
   assign burst_len  = !busy ? 4'd0 : (len8 ? 4'd8 : 4'd4);
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
   parameter int unsigned COL_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_ready,
   input logic             beat_valid,
   input logic [COL_W-1:0] beat_col,
   input logic             beat_last,
   input logic [3:0]       burst_len,
   input logic             mode_err
);
   logic [3:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else if (beat_valid) cnt <= beat_last ? 4'd0 : cnt + 4'd1;
   end

   p_len_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid |-> (burst_len == 4'd4 || burst_len == 4'd8));

   p_err_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |-> !beat_valid);

   p_hold_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid && !beat_last |=> beat_col[COL_W-1:3] == $past(beat_col[COL_W-1:3]));

   p_hold_chop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid && !beat_last && burst_len == 4'd4 |=> beat_col[2] == $past(beat_col[2]));

   p_contig_r8: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid && !beat_last |=> beat_valid && $stable(burst_len));

   p_last_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
      beat_last |-> beat_valid && cnt == burst_len - 4'd1);

   p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid |-> !cmd_ready);

   p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      beat_last |=> cmd_ready);
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_ready  (cmd_ready),
   .beat_valid (beat_valid),
   .beat_col   (beat_col),
   .beat_last  (beat_last),
   .burst_len  (burst_len),
   .mode_err   (mode_err)
);

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
   localparam int COL_W = 10;
   localparam time CLK_PERIOD = 10ns;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_valid = 1'b0;
   logic             cmd_ready;
   logic [COL_W-1:0] cmd_col = '0;
   logic             cmd_a12 = 1'b0;
   logic [1:0]       bl_mode = 2'b00;
   logic             burst_type = 1'b0;
   logic             beat_valid;
   logic [COL_W-1:0] beat_col;
   logic             beat_last;
   logic [3:0]       burst_len;
   logic             mode_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_col(cmd_col), .cmd_a12(cmd_a12), .bl_mode(bl_mode),
      .burst_type(burst_type), .beat_valid(beat_valid), .beat_col(beat_col),
      .beat_last(beat_last), .burst_len(burst_len), .mode_err(mode_err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_col(input int col, input int len, input bit ilv, input int k);
      int msk;
      int off;
      msk = len - 1;
      off = ilv ? ((col & msk) ^ k) : (((col & msk) + k) & msk);
      return (col & ~msk & ((1 << COL_W) - 1)) | off;
   endfunction

   task automatic run_burst(input int mode, input bit a12, input bit ilv, input int col);
      int len;
      len = (mode == 0) ? 8 : (mode == 2) ? 4 : (a12 ? 8 : 4);
      check(cmd_ready == 1'b1, "R9 ready before cmd", int'(cmd_ready), 1);
      cmd_valid  = 1'b1;
      bl_mode    = mode[1:0];
      cmd_a12    = a12;
      burst_type = ilv;
      cmd_col    = col[COL_W-1:0];
      @(negedge clk);
      // R10 / R9: scramble inputs and keep offering a command mid-burst
      bl_mode    = (mode == 0) ? 2'b10 : 2'b00;
      cmd_a12    = ~a12;
      burst_type = ~ilv;
      cmd_col    = ~col[COL_W-1:0];
      for (int k = 0; k < len; k++) begin
         check(beat_valid == 1'b1, "R8 beat valid", int'(beat_valid), 1);
         check(int'(burst_len) == len, (mode == 1) ? "R3 otf length" : "R2 fixed length",
               int'(burst_len), len);
         check(int'(beat_col) == exp_col(col, len, ilv, k),
               ilv ? "R7 R5 R10 interleaved col" : "R6 R5 R10 sequential col",
               int'(beat_col), exp_col(col, len, ilv, k));
         check(beat_last == (k == len - 1), "R8 last flag", int'(beat_last), int'(k == len - 1));
         check(cmd_ready == 1'b0, "R9 ready low in burst", int'(cmd_ready), 0);
         if (k == len - 1) cmd_valid = 1'b0;
         @(negedge clk);
      end
      check(beat_valid == 1'b0, "R9 no extra burst", int'(beat_valid), 0);
      check(cmd_ready == 1'b1, "R9 ready after last", int'(cmd_ready), 1);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int n;
      n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(beat_valid == 1'b0, "R1 reset valid", int'(beat_valid), 0);
      check(beat_last == 1'b0, "R1 reset last", int'(beat_last), 0);
      check(mode_err == 1'b0, "R1 reset err", int'(mode_err), 0);
      check(burst_len == 4'd0, "R1 reset len", int'(burst_len), 0);
      check(cmd_ready == 1'b1, "R1 reset ready", int'(cmd_ready), 1);

      for (int m = 0; m < 3; m++)
         for (int a = 0; a < 2; a++)
            for (int t = 0; t < 2; t++)
               for (int s = 0; s < 8; s++) begin
                  n++;
                  run_burst(m, a[0], t[0], (((n * 37) % 128) << 3) | s);
               end

      // R4: reserved mode
      cmd_valid = 1'b1;
      bl_mode   = 2'b11;
      cmd_col   = 10'h155;
      @(negedge clk);
      cmd_valid = 1'b0;
      bl_mode   = 2'b00;
      check(mode_err == 1'b1, "R4 err pulse", int'(mode_err), 1);
      check(beat_valid == 1'b0, "R4 no burst", int'(beat_valid), 0);
      check(cmd_ready == 1'b1, "R4 ready stays", int'(cmd_ready), 1);
      @(negedge clk);
      check(mode_err == 1'b0, "R4 err one cycle", int'(mode_err), 0);
      check(beat_valid == 1'b0, "R4 still idle", int'(beat_valid), 0);

      run_burst(1, 1'b1, 1'b0, 10'h3FF);
      run_burst(1, 1'b0, 1'b1, 10'h000);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule